// File: doc/BRIEF.md
# Processor Performance Monitor

This block counts activity inside a CPU core. It has one cycle counter and two event counters, each 32 bits wide. A single control word holds the global run bit, the interrupt masks, the overflow flags and the two 8-bit event codes. Each event counter follows the input line that its event code picks from a bus of single-cycle event pulses.

No counter has its own enable. To stop an event counter, software gives it a code that no input drives. The cycle counter runs whenever the global run bit is set, either on every clock or, with the divider bit set, once every 64 clocks.

A narrow register port gives read and write access to the control word and to each counter. Each counter that wraps from all ones to zero sets a sticky flag. One interrupt line is raised when any flag is set together with its mask bit. Software clears a flag by writing a 1 to its bit in the control word, so writing back a value just read clears the flags that were seen.

Top module: `perf_mon`

## Requirements
- R1: After reset the control word and all three counters read 0 and `irq` is low.
- R2: While control bit 0 (global run) is 0, no counter changes except by a register write or a clear bit.
- R3: While running, the cycle counter advances on every clock if control bit 3 is 0. If bit 3 is 1, it advances once per 64 run cycles, counted from its last clear or write.
- R4: Event counter 0 takes its code from control bits [27:20] and event counter 1 from bits [19:12]. A code c below 19 adds 1 on every run cycle in which `evtIn[c]` is high. Code 0xFF adds 1 on every run cycle.
- R5: Any other code, including the parking code 0x20, never advances the counter.
- R6: Writing 1 to control bit 1 clears both event counters. Writing 1 to bit 2 clears the cycle counter and its divider phase. Both bits always read as 0.
- R7: Register address 0 selects the control word, 1 the cycle counter, 2 event counter 0 and 3 event counter 1. A counter write in a run cycle stores the written value and drops that cycle's increment.
- R8: A wrap from all ones to zero sets flag bit 8 (event counter 0), bit 9 (event counter 1) or bit 10 (cycle counter). The flag is set after the same edge at which the counter becomes 0.
- R9: Writing a control word with 1 in a flag bit clears that flag, and a 0 leaves it unchanged. Writing back the word just read leaves every other field at its read value.
- R10: `irq` is high whenever a flag is set together with its mask bit: bit 4 for event counter 0, bit 5 for event counter 1, bit 6 for the cycle counter. The cycle counter's mask bit does not affect whether it counts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| wrEn | input | 1 | Register write strobe |
| regAddr | input | 2 | Register select: 0 control, 1 cycle, 2 event 0, 3 event 1 |
| wrData | input | 32 | Write data |
| rdData | output | 32 | Read data for `regAddr`, combinational |
| evtIn | input | 19 | Event pulse inputs, one per code 0x00 to 0x12 |
| irq | output | 1 | Combined overflow interrupt |

## Verification
A register write takes effect at the clock edge on which `wrEn` is sampled, and reads are combinational. The bench therefore reads back one settled moment after the falling edge that follows the write.

Counting starts at the first edge after the edge that sets the run bit, and it includes the edge that clears the run bit. Every expected count is built from that edge arithmetic: the number of driven pattern cycles plus the stopping edge for the cycle counter and code 0xFF.

Overflow flags and `irq` are checked on both sides of the wrapping edge. The bench samples one cycle before the wrap, when they must still be low, and right after it, when they must be high.

// File: rtl/perf_mon_pkg.sv
package perf_mon_pkg;
  localparam int DATA_W = 32;

  // control word bit positions (software-visible layout)
  localparam int CB_RUN    = 0;
  localparam int CB_EVCLR  = 1;
  localparam int CB_CYCCLR = 2;
  localparam int CB_DIV    = 3;
  localparam int CB_IE_LO  = 4;   // 4: ev0, 5: ev1, 6: cycle
  localparam int CB_OVF_LO = 8;   // 8: ev0, 9: ev1, 10: cycle
  localparam int CB_CODE1  = 12;  // [19:12]
  localparam int CB_CODE0  = 20;  // [27:20]

  typedef enum logic [1:0] {
    SEL_CTRL = 2'd0,
    SEL_CYC  = 2'd1,
    SEL_EV0  = 2'd2,
    SEL_EV1  = 2'd3
  } regSel_e;

  typedef struct packed {
    logic       cycClr;
    logic       evtClr;
    logic       cycWr;
    logic [1:0] evtWr;
  } strobe_t;
endpackage

// File: rtl/perf_mon_ctrl.sv
module perf_mon_ctrl
  import perf_mon_pkg::*;
#(
  parameter int CNT_W  = 32,
  parameter int CODE_W = 8
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  logic                        wrEn,
  input  logic [1:0]                  regAddr,
  input  logic [DATA_W-1:0]           wrData,
  input  logic [2:0]                  ovfPulse,
  input  logic [CNT_W-1:0]            cycVal,
  input  logic [1:0][CNT_W-1:0]       evtVal,
  output strobe_t                     strobe,
  output logic                        globalEn,
  output logic                        divSel,
  output logic [1:0][CODE_W-1:0]      evtCode,
  output logic [DATA_W-1:0]           rdData,
  output logic                        irq
);
  logic       ctrlWr;
  logic [2:0] ieReg;
  logic [2:0] flagReg;
  logic [2:0] flagClr;
  logic       unusedBits;

  assign unusedBits = ^{wrData[31:28], wrData[11], wrData[7]};

  assign ctrlWr  = wrEn && (regSel_e'(regAddr) == SEL_CTRL);
  assign flagClr = ctrlWr ? wrData[CB_OVF_LO +: 3] : 3'b000;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      globalEn <= 1'b0;
      divSel   <= 1'b0;
      ieReg    <= '0;
      evtCode  <= '0;
    end else if (ctrlWr) begin
      globalEn   <= wrData[CB_RUN];
      divSel     <= wrData[CB_DIV];
      ieReg      <= wrData[CB_IE_LO +: 3];
      evtCode[0] <= wrData[CB_CODE0 +: CODE_W];
      evtCode[1] <= wrData[CB_CODE1 +: CODE_W];
    end
  end

  // a fresh overflow wins over a clear in the same cycle
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) flagReg <= '0;
    else       flagReg <= (flagReg & ~flagClr) | ovfPulse;
  end

  always_comb begin
    strobe.cycClr = ctrlWr && wrData[CB_CYCCLR];
    strobe.evtClr = ctrlWr && wrData[CB_EVCLR];
    strobe.cycWr  = wrEn && (regSel_e'(regAddr) == SEL_CYC);
    strobe.evtWr  = {wrEn && (regSel_e'(regAddr) == SEL_EV1),
                     wrEn && (regSel_e'(regAddr) == SEL_EV0)};
  end

  always_comb begin
    rdData = '0;
    unique case (regSel_e'(regAddr))
      SEL_CTRL: begin
        rdData[CB_RUN]                = globalEn;
        rdData[CB_DIV]                = divSel;
        rdData[CB_IE_LO +: 3]         = ieReg;
        rdData[CB_OVF_LO +: 3]        = flagReg;
        rdData[CB_CODE0 +: CODE_W]    = evtCode[0];
        rdData[CB_CODE1 +: CODE_W]    = evtCode[1];
      end
      SEL_CYC: rdData = DATA_W'(cycVal);
      SEL_EV0: rdData = DATA_W'(evtVal[0]);
      SEL_EV1: rdData = DATA_W'(evtVal[1]);
      default: rdData = '0;
    endcase
  end

  assign irq = |(flagReg & ieReg);

  for (genvar i = 0; i < 3; i++) begin : g_flagChk
    AST_FLAG_SET: assert property (@(posedge clk) disable iff (!rstN)
      ovfPulse[i] |=> flagReg[i]); // R8
    AST_FLAG_CLEAR: assert property (@(posedge clk) disable iff (!rstN)
      ctrlWr && wrData[CB_OVF_LO + i] && !ovfPulse[i] |=> !flagReg[i]); // R9
    AST_FLAG_KEEP: assert property (@(posedge clk) disable iff (!rstN)
      flagReg[i] && !(ctrlWr && wrData[CB_OVF_LO + i]) |=> flagReg[i]); // R9
  end
endmodule

// File: rtl/perf_mon_datapath.sv
module perf_mon_datapath
  import perf_mon_pkg::*;
#(
  parameter int              CNT_W     = 32,
  parameter int              CODE_W    = 8,
  parameter int              NUM_EVT   = 19,
  parameter int              DIV_LOG2  = 6,
  parameter logic [CODE_W-1:0] ALL_CODE  = 8'hFF,
  parameter logic [CODE_W-1:0] PARK_CODE = 8'h20
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  strobe_t                strobe,
  input  logic                   globalEn,
  input  logic                   divSel,
  input  logic [1:0][CODE_W-1:0] evtCode,
  input  logic [NUM_EVT-1:0]     evtIn,
  input  logic [CNT_W-1:0]       wrData,
  output logic [CNT_W-1:0]       cycVal,
  output logic [1:0][CNT_W-1:0]  evtVal,
  output logic [2:0]             ovfPulse
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [DIV_LOG2-1:0] preCnt;
  logic                preTick;
  logic                cycInc;
  logic                cycLoad;

  function automatic logic eventHit(input logic [CODE_W-1:0] code,
                                    input logic [NUM_EVT-1:0] lines);
    logic hit;
    hit = (code == ALL_CODE);
    for (int j = 0; j < NUM_EVT; j++)
      if (code == CODE_W'(j)) hit = lines[j];
    return hit;
  endfunction

  assign preTick = &preCnt;
  assign cycLoad = strobe.cycWr || strobe.cycClr;
  assign cycInc  = globalEn && (!divSel || preTick);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                     preCnt <= '0;
    else if (cycLoad)              preCnt <= '0;
    else if (globalEn && divSel)   preCnt <= preCnt + 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              cycVal <= '0;
    else if (strobe.cycWr)  cycVal <= wrData;
    else if (strobe.cycClr) cycVal <= '0;
    else if (cycInc)        cycVal <= cycVal + 1'b1;
  end

  assign ovfPulse[2] = cycInc && !cycLoad && (cycVal == CNT_MAX);

  for (genvar g = 0; g < 2; g++) begin : g_evt
    logic evtInc;
    assign evtInc = globalEn && eventHit(evtCode[g], evtIn);

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)                 evtVal[g] <= '0;
      else if (strobe.evtWr[g])  evtVal[g] <= wrData;
      else if (strobe.evtClr)    evtVal[g] <= '0;
      else if (evtInc)           evtVal[g] <= evtVal[g] + 1'b1;
    end

    assign ovfPulse[g] = evtInc && !strobe.evtWr[g] && !strobe.evtClr &&
                         (evtVal[g] == CNT_MAX);

    AST_PARKED_STILL: assert property (@(posedge clk) disable iff (!rstN)
      evtCode[g] == PARK_CODE && !strobe.evtWr[g] && !strobe.evtClr
      |=> $stable(evtVal[g])); // R5
    AST_EVT_CLEARED: assert property (@(posedge clk) disable iff (!rstN)
      strobe.evtClr && !strobe.evtWr[g] |=> evtVal[g] == '0); // R6
  end

  AST_HOLD_WHEN_OFF: assert property (@(posedge clk) disable iff (!rstN)
    !globalEn && !cycLoad |=> $stable(cycVal)); // R2
  AST_WRITE_WINS: assert property (@(posedge clk) disable iff (!rstN)
    strobe.cycWr |=> cycVal == $past(wrData)); // R7
  AST_WRAP_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    ovfPulse[2] |=> cycVal == '0); // R8
endmodule

// File: rtl/perf_mon.sv
module perf_mon
  import perf_mon_pkg::*;
#(
  parameter int CNT_W    = 32,
  parameter int NUM_EVT  = 19,
  parameter int DIV_LOG2 = 6
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               wrEn,
  input  logic [1:0]         regAddr,
  input  logic [DATA_W-1:0]  wrData,
  output logic [DATA_W-1:0]  rdData,
  input  logic [NUM_EVT-1:0] evtIn,
  output logic               irq
);
  localparam int CODE_W = 8;

  strobe_t                 strobe;
  logic                    globalEn;
  logic                    divSel;
  logic [1:0][CODE_W-1:0]  evtCode;
  logic [CNT_W-1:0]        cycVal;
  logic [1:0][CNT_W-1:0]   evtVal;
  logic [2:0]              ovfPulse;

  perf_mon_ctrl #(.CNT_W(CNT_W), .CODE_W(CODE_W)) ctrl_i (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .regAddr(regAddr), .wrData(wrData),
    .ovfPulse(ovfPulse), .cycVal(cycVal), .evtVal(evtVal), .strobe(strobe),
    .globalEn(globalEn), .divSel(divSel), .evtCode(evtCode),
    .rdData(rdData), .irq(irq)
  );

  perf_mon_datapath #(
    .CNT_W(CNT_W), .CODE_W(CODE_W), .NUM_EVT(NUM_EVT), .DIV_LOG2(DIV_LOG2)
  ) dp_i (
    .clk(clk), .rstN(rstN), .strobe(strobe), .globalEn(globalEn),
    .divSel(divSel), .evtCode(evtCode), .evtIn(evtIn),
    .wrData(wrData[CNT_W-1:0]), .cycVal(cycVal), .evtVal(evtVal),
    .ovfPulse(ovfPulse)
  );
endmodule

// File: tb/perf_mon_tb_top.sv
module perf_mon_tb_top;
  localparam int NUM_EVT = 19;
  localparam int NPAT    = 12;

  logic               clk = 1'b0;
  logic               rstN = 1'b0;
  logic               wrEn = 1'b0;
  logic [1:0]         regAddr = '0;
  logic [31:0]        wrData = '0;
  logic [31:0]        rdData;
  logic [NUM_EVT-1:0] evtIn = '0;
  logic               irq;

  int checks = 0;
  int fails  = 0;

  perf_mon dut_i (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .regAddr(regAddr), .wrData(wrData),
    .rdData(rdData), .evtIn(evtIn), .irq(irq)
  );

  always #10 clk = ~clk;

  function automatic logic [31:0] ctrlWord(input bit run, input bit evClr,
      input bit cyClr, input bit dv, input logic [2:0] ie, input logic [2:0] fl,
      input logic [7:0] c0, input logic [7:0] c1);
    logic [31:0] w;
    w = '0;
    w[0] = run; w[1] = evClr; w[2] = cyClr; w[3] = dv;
    w[6:4] = ie; w[10:8] = fl; w[27:20] = c0; w[19:12] = c1;
    return w;
  endfunction

  function automatic bit patBit(input int k, input int i);
    return ((k * 5 + i * 3) % 7) < 3;
  endfunction

  function automatic logic [31:0] expEvt(input int code);
    int n;
    n = 0;
    if (code == 255) return NPAT + 1;
    if (code >= NUM_EVT) return 0;
    for (int k = 0; k < NPAT; k++) if (patBit(k, code)) n++;
    return n;
  endfunction

  task automatic check(input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    regAddr = a; wrData = d; wrEn = 1'b1;
    @(negedge clk);
    wrEn = 1'b0;
    #1;
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] d);
    regAddr = a;
    #1 d = rdData;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    logic [31:0] v, w;
    logic [7:0] c1;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    #1;
    // R1 reset state
    for (int a = 0; a < 4; a++) begin
      rd(a[1:0], v);
      check($sformatf("R1 reg %0d after reset", a), v, 0);
    end
    check("R1 irq after reset", {31'd0, irq}, 0);

    // R3 R4 R5 sweep over every event code
    for (int code = 0; code < 256; code++) begin
      c1 = 8'(code + 7);
      wr(0, ctrlWord(0, 1, 1, 0, 3'b000, 3'b000, 8'(code), c1));
      wr(0, ctrlWord(1, 0, 0, 0, 3'b000, 3'b000, 8'(code), c1));
      for (int k = 0; k < NPAT; k++) begin
        for (int i = 0; i < NUM_EVT; i++) evtIn[i] = patBit(k, i);
        @(negedge clk);
      end
      evtIn = '0;
      wr(0, ctrlWord(0, 0, 0, 0, 3'b000, 3'b000, 8'(code), c1));
      rd(2, v);
      check($sformatf("R4/R5 ev0 code %0h", code), v, expEvt(code));
      rd(3, v);
      check($sformatf("R4/R5 ev1 code %0h", c1), v, expEvt(int'(c1)));
      rd(1, v);
      check($sformatf("R3 cycle count code %0h", code), v, NPAT + 1);
    end

    // R2 stopped counters hold with all events high
    evtIn = '1;
    wr(0, ctrlWord(0, 0, 0, 0, 3'b000, 3'b000, 8'hFF, 8'h00));
    rd(1, w);
    repeat (10) @(negedge clk);
    rd(1, v);
    check("R2 cycle holds when stopped", v, w);
    rd(2, v);
    check("R2 ev0 holds when stopped", v, expEvt(255));
    evtIn = '0;

    // R3 divider
    wr(0, ctrlWord(0, 1, 1, 0, 3'b000, 3'b000, 8'h20, 8'h20));
    wr(0, ctrlWord(1, 0, 0, 1, 3'b000, 3'b000, 8'h20, 8'h20));
    repeat (200) @(negedge clk);
    wr(0, ctrlWord(0, 0, 0, 1, 3'b000, 3'b000, 8'h20, 8'h20));
    rd(1, v);
    check("R3 divided cycle count", v, 201 / 64);

    // R6 clear bits
    wr(1, 32'd55); wr(2, 32'd66); wr(3, 32'd77);
    wr(0, ctrlWord(0, 1, 0, 0, 3'b000, 3'b000, 8'h20, 8'h20));
    rd(1, v); check("R6 evclr keeps cycle", v, 55);
    rd(2, v); check("R6 evclr ev0", v, 0);
    rd(3, v); check("R6 evclr ev1", v, 0);
    rd(0, v); check("R6 clear bits read zero", {30'd0, v[2:1]}, 0);
    wr(2, 32'd66);
    wr(0, ctrlWord(0, 0, 1, 0, 3'b000, 3'b000, 8'h20, 8'h20));
    rd(1, v); check("R6 cyclr cycle", v, 0);
    rd(2, v); check("R6 cyclr keeps ev0", v, 66);

    // R8 R10 event 0 overflow
    wr(0, ctrlWord(0, 0, 0, 0, 3'b001, 3'b000, 8'hFF, 8'h20));
    wr(2, 32'hFFFF_FFFD);
    wr(0, ctrlWord(1, 0, 0, 0, 3'b001, 3'b000, 8'hFF, 8'h20));
    @(negedge clk); @(negedge clk); #1;
    rd(0, v); check("R8 flag clear before wrap", {31'd0, v[8]}, 0);
    check("R10 irq low before wrap", {31'd0, irq}, 0);
    @(negedge clk); #1;
    rd(2, v); check("R8 ev0 wrapped to zero", v, 0);
    rd(0, v); check("R8 ev0 flag bit 8", {29'd0, v[10:8]}, 3'b001);
    check("R10 irq high on ev0 overflow", {31'd0, irq}, 1);
    wr(0, ctrlWord(0, 0, 0, 0, 3'b001, 3'b000, 8'hFF, 8'h20));
    check("R9 flag kept when written 0", {31'd0, irq}, 1);
    rd(0, v);
    wr(0, v);
    rd(0, w);
    check("R9 write-back clears flag", {29'd0, w[10:8]}, 0);
    check("R9 write-back keeps fields", w, v & ~32'h0000_0700);
    check("R10 irq low after clear", {31'd0, irq}, 0);

    // R10 cycle overflow masked, counting continues
    wr(1, 32'hFFFF_FFFE);
    wr(0, ctrlWord(1, 0, 0, 0, 3'b000, 3'b000, 8'h20, 8'h20));
    @(negedge clk); @(negedge clk); #1;
    rd(1, v); check("R8 cycle wrapped with mask off", v, 0);
    rd(0, v); check("R8 cycle flag bit 10", {29'd0, v[10:8]}, 3'b100);
    check("R10 irq masked", {31'd0, irq}, 0);
    wr(0, ctrlWord(0, 0, 0, 0, 3'b100, 3'b000, 8'h20, 8'h20));
    check("R10 irq after unmask", {31'd0, irq}, 1);
    wr(0, ctrlWord(0, 0, 0, 0, 3'b100, 3'b100, 8'h20, 8'h20));
    check("R10 irq after cycle flag clear", {31'd0, irq}, 0);

    // R7 write wins over increment
    wr(0, ctrlWord(1, 0, 0, 0, 3'b000, 3'b000, 8'h20, 8'hFF));
    wr(3, 32'd100);
    rd(3, v); check("R7 write beats increment", v, 100);
    @(negedge clk); #1;
    rd(3, v); check("R7 counts on after write", v, 101);
    wr(0, ctrlWord(0, 0, 0, 0, 3'b000, 3'b000, 8'h20, 8'hFF));
    rd(3, v); check("R7 final ev1 value", v, 102);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule